// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block is a small fully associative table that turns the upper bits of an effective address into a virtual segment descriptor. Every slot holds two 64-bit words. The tag word carries the segment number and a valid flag. The descriptor word carries a two-bit segment-size code plus key, no-execute, large-page and virtual segment bits. The array stores the descriptor bits and returns them unchanged. Each entry matches either a 256 MB or a 1 TB segment, chosen by the size code held in that same entry.

A lookup port compares one address against all slots in a single cycle and returns a registered result in the following cycle: a hit flag, the index of the winning slot and that slot's descriptor word. A separate command port accepts one operation per cycle. The operations are: write a slot, read back either word of a slot, invalidate the slot that matches an address, and invalidate all slots except slot 0. A command that breaks the legality rules raises a one-cycle program-error pulse. An invalidate that actually clears a valid flag raises a one-cycle flush request, which tells a downstream translation cache to drop its contents.

The whole block works in single cycles, so it has no sequencing state. Every command completes at the clock edge that accepts it. All outputs are registered at that same edge.

Top module: `slb_array`

## Requirements
- R1: After reset both words of every slot read as zero, and no lookup hits.
- R2: The tag word is laid out as follows: bits [63:28] hold the segment field and bit 27 holds the valid flag. In the descriptor word, bits [63:62] hold the size code, where 00 means 256 MB and 01 means 1 TB. A slot with size code 00 hits when its tag word equals the address with bits [27:0] cleared and bit 27 set.
- R3: A slot with size code 01 hits when its tag word equals the address with bits [39:0] cleared and bit 27 set. Address bits [39:28] therefore play no part in the match.
- R4: When several slots match, the lookup reports the lowest-index slot and that slot's descriptor word. On a miss, the index and descriptor outputs are zero.
- R5: A lookup request at one clock edge produces lk_vld_o, together with its hit, index and descriptor, in the very next cycle only.
- R6: A legal write takes the slot number from bits [11:0] of the index operand. It stores the index operand ANDed with bits [63:27] into the tag word, and it stores the data operand unchanged into the descriptor word.
- R7: A write is rejected with a program-error pulse, and with no change to any slot, when any bit of [11:0] of the index operand is set at a position whose value is at or above the slot count.
- R8: A write is also rejected when its size code is 10 or 11, or when the size code is 01 while seg1t_en is low.
- R9: A read (op 2 for the tag word, op 3 for the descriptor word) whose bits [11:0] are at or above the slot count raises a program-error pulse and no rd_vld_o. A legal read returns the word on rd_data_o with rd_vld_o. Outside a legal read, rd_data_o is zero.
- R10: Invalidate-all (op 5) clears the valid flag of every slot from 1 upward and never alters slot 0. It pulses flush_o only if at least one flag was actually cleared.
- R11: Invalidate-by-address (op 4) clears the valid flag of the lowest-index slot that matches the address operand and pulses flush_o. A miss changes nothing and does not flush.
- R12: A lookup in the same cycle as a command sees the slot contents from before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg1t_en | input | 1 | Allows 1 TB entries to be written |
| lk_req | input | 1 | Lookup request |
| lk_ea | input | 64 | Lookup effective address |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 1 write, 2 read tag, 3 read descriptor, 4 invalidate by address, 5 invalidate all |
| cmd_index | input | 64 | Tag and slot operand, or the address for op 4 |
| cmd_data | input | 64 | Descriptor word to write |
| lk_vld_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Lookup hit |
| lk_idx_o | output | 5 | Winning slot index |
| lk_vsid_o | output | 64 | Winning descriptor word |
| rd_vld_o | output | 1 | Read data valid |
| rd_data_o | output | 64 | Read data |
| prog_err_o | output | 1 | Illegal command pulse |
| flush_o | output | 1 | Translation cache flush request |

## Verification
A lookup and a command can fall in the same cycle. The most telling pairing is a lookup together with an invalidate or a write that touches the very slot being looked up. The bench provokes this by driving both ports on most random cycles. It draws addresses from a small pool of segment values so that hits and overlapping 256 MB and 1 TB entries are common. Directed steps then pair a lookup of a slot with its own invalidation. The bench judges each lookup against a model evaluated before that cycle's command is applied, so the result must still show the old entry even while the flush pulse for that same slot appears.

// File: rtl/slb_pkg.sv
package slb_pkg;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_WRITE    = 3'd1,
        OP_RD_TAG   = 3'd2,
        OP_RD_DESC  = 3'd3,
        OP_INV_ADDR = 3'd4,
        OP_INV_ALL  = 3'd5
    } slb_op_e;

    localparam logic [1:0] SZ_256M = 2'b00;
    localparam logic [1:0] SZ_1T   = 2'b01;

    localparam int SEG_S_LSB = 28;
    localparam int SEG_L_LSB = 40;
    localparam int VLD_BIT   = 27;
    localparam int SLOT_FLD  = 12;

endpackage

// File: rtl/slb_entry_match.sv
module slb_entry_match
    import slb_pkg::*;
#(
    parameter int EA_W = 64
) (
    input  logic [EA_W-1:0] tag_w,
    input  logic [1:0]      size_c,
    input  logic [EA_W-1:0] ea,
    output logic            hit
);
    localparam logic [EA_W-1:0] MASK_S = {EA_W{1'b1}} << SEG_S_LSB;
    localparam logic [EA_W-1:0] MASK_L = {EA_W{1'b1}} << SEG_L_LSB;
    localparam logic [EA_W-1:0] VLD_M  = {{(EA_W-1){1'b0}}, 1'b1} << VLD_BIT;

    logic [EA_W-1:0] key_s;
    logic [EA_W-1:0] key_l;

    always_comb begin
        key_s = (ea & MASK_S) | VLD_M;
        key_l = (ea & MASK_L) | VLD_M;
        hit   = ((tag_w == key_s) && (size_c == SZ_256M)) ||
                ((tag_w == key_l) && (size_c == SZ_1T));
    end
endmodule

// File: rtl/slb_prio_enc.sv
module slb_prio_enc #(
    parameter int N  = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/slb_cmd_check.sv
module slb_cmd_check
    import slb_pkg::*;
#(
    parameter int NSLOTS = 32,
    parameter int EA_W   = 64
) (
    input  logic            cmd_valid,
    input  slb_op_e         op,
    input  logic [EA_W-1:0] index_w,
    input  logic [EA_W-1:0] data_w,
    input  logic            seg1t_en,
    output logic            wr_ok,
    output logic            rd_ok,
    output logic            err
);
    localparam logic [SLOT_FLD-1:0] RSV_MASK = SLOT_FLD'((1 << SLOT_FLD) - NSLOTS);

    logic [SLOT_FLD-1:0] slot_f;
    logic [1:0]          size_c;
    logic                wr_bad;
    logic                rd_bad;
    logic                is_wr;
    logic                is_rd;

    always_comb begin
        slot_f = index_w[SLOT_FLD-1:0];
        size_c = data_w[EA_W-1 -: 2];
        is_wr  = cmd_valid && (op == OP_WRITE);
        is_rd  = cmd_valid && ((op == OP_RD_TAG) || (op == OP_RD_DESC));
        wr_bad = ((slot_f & RSV_MASK) != '0) ||
                 (size_c[1] == 1'b1) ||
                 ((size_c == SZ_1T) && !seg1t_en);
        rd_bad = (32'(slot_f) >= NSLOTS);
        wr_ok  = is_wr && !wr_bad;
        rd_ok  = is_rd && !rd_bad;
        err    = (is_wr && wr_bad) || (is_rd && rd_bad);
    end
endmodule

// File: rtl/slb_array.sv
module slb_array
    import slb_pkg::*;
#(
    parameter int NSLOTS = 32,
    parameter int EA_W   = 64,
    localparam int IW    = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            seg1t_en,
    input  logic            lk_req,
    input  logic [EA_W-1:0] lk_ea,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic [EA_W-1:0] cmd_index,
    input  logic [EA_W-1:0] cmd_data,
    output logic            lk_vld_o,
    output logic            lk_hit_o,
    output logic [IW-1:0]   lk_idx_o,
    output logic [EA_W-1:0] lk_vsid_o,
    output logic            rd_vld_o,
    output logic [EA_W-1:0] rd_data_o,
    output logic            prog_err_o,
    output logic            flush_o
);
    localparam logic [EA_W-1:0] KEEP_M = {EA_W{1'b1}} << VLD_BIT;

    logic [EA_W-1:0] tag_q  [NSLOTS];
    logic [EA_W-1:0] desc_q [NSLOTS];

    logic [NSLOTS-1:0] lk_match;
    logic [NSLOTS-1:0] cm_match;
    logic [NSLOTS-1:0] vld_vec;

    slb_op_e       op;
    logic          wr_ok;
    logic          rd_ok;
    logic          err;
    logic          lk_found;
    logic [IW-1:0] lk_sel;
    logic          cm_found;
    logic [IW-1:0] cm_sel;
    logic [IW-1:0] slot_i;
    logic          inv_all;
    logic          inv_addr;
    logic          rest_valid;

    assign op = slb_op_e'(cmd_op);

    for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
        slb_entry_match #(.EA_W(EA_W)) u_lk_m (
            .tag_w  (tag_q[g]),
            .size_c (desc_q[g][EA_W-1 -: 2]),
            .ea     (lk_ea),
            .hit    (lk_match[g])
        );
        slb_entry_match #(.EA_W(EA_W)) u_cm_m (
            .tag_w  (tag_q[g]),
            .size_c (desc_q[g][EA_W-1 -: 2]),
            .ea     (cmd_index),
            .hit    (cm_match[g])
        );
        assign vld_vec[g] = tag_q[g][VLD_BIT];
    end

    slb_prio_enc #(.N(NSLOTS)) u_lk_pe (
        .req   (lk_match),
        .found (lk_found),
        .idx   (lk_sel)
    );

    slb_prio_enc #(.N(NSLOTS)) u_cm_pe (
        .req   (cm_match),
        .found (cm_found),
        .idx   (cm_sel)
    );

    slb_cmd_check #(.NSLOTS(NSLOTS), .EA_W(EA_W)) u_chk (
        .cmd_valid (cmd_valid),
        .op        (op),
        .index_w   (cmd_index),
        .data_w    (cmd_data),
        .seg1t_en  (seg1t_en),
        .wr_ok     (wr_ok),
        .rd_ok     (rd_ok),
        .err       (err)
    );

    always_comb begin
        slot_i     = cmd_index[IW-1:0];
        inv_all    = cmd_valid && (op == OP_INV_ALL);
        inv_addr   = cmd_valid && (op == OP_INV_ADDR);
        rest_valid = (vld_vec >> 1) != '0;
    end

    // Slot storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOTS; i++) begin
                tag_q[i]  <= '0;
                desc_q[i] <= '0;
            end
        end else begin
            if (wr_ok) begin
                tag_q[slot_i]  <= cmd_index & KEEP_M;
                desc_q[slot_i] <= cmd_data;
            end
            if (inv_all) begin
                for (int i = 1; i < NSLOTS; i++) begin
                    tag_q[i][VLD_BIT] <= 1'b0;
                end
            end
            if (inv_addr && cm_found) begin
                tag_q[cm_sel][VLD_BIT] <= 1'b0;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_vld_o   <= 1'b0;
            lk_hit_o   <= 1'b0;
            lk_idx_o   <= '0;
            lk_vsid_o  <= '0;
            rd_vld_o   <= 1'b0;
            rd_data_o  <= '0;
            prog_err_o <= 1'b0;
            flush_o    <= 1'b0;
        end else begin
            lk_vld_o   <= lk_req;
            lk_hit_o   <= lk_req && lk_found;
            lk_idx_o   <= (lk_req && lk_found) ? lk_sel : '0;
            lk_vsid_o  <= (lk_req && lk_found) ? desc_q[lk_sel] : '0;
            rd_vld_o   <= rd_ok;
            rd_data_o  <= !rd_ok ? '0 :
                          (op == OP_RD_TAG) ? tag_q[slot_i] : desc_q[slot_i];
            prog_err_o <= err;
            flush_o    <= (inv_all && rest_valid) || (inv_addr && cm_found);
        end
    end

    assert_lookup_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_vld_o);
    assert_no_spurious_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_vld_o && !lk_hit_o);
    assert_slot0_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> tag_q[0] == $past(tag_q[0]));
    assert_flush_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> $past(inv_all || inv_addr));
    assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_err_o |-> $past(cmd_valid && (op == OP_WRITE || op == OP_RD_TAG || op == OP_RD_DESC)));
    assert_rd_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_vld_o && prog_err_o));

endmodule

// File: tb/slb_array_tb.sv
module slb_array_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg1t_en = 1'b1;
    logic        lk_req = 1'b0;
    logic [63:0] lk_ea = '0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [63:0] cmd_index = '0;
    logic [63:0] cmd_data = '0;
    logic        lk_vld_o, lk_hit_o, rd_vld_o, prog_err_o, flush_o;
    logic [4:0]  lk_idx_o;
    logic [63:0] lk_vsid_o, rd_data_o;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [63:0] KEEP = 64'hFFFF_FFFF_F800_0000;
    localparam logic [63:0] MS   = 64'hFFFF_FFFF_F000_0000;
    localparam logic [63:0] ML   = 64'hFFFF_FF00_0000_0000;
    localparam logic [63:0] VB   = 64'h0000_0000_0800_0000;

    logic [63:0] m_tag  [32];
    logic [63:0] m_desc [32];
    logic [23:0] pool_hi  [4];
    logic [11:0] pool_mid [4];

    always #2 clk = ~clk;

    slb_array dut_i (
        .clk(clk), .rst_n(rst_n), .seg1t_en(seg1t_en),
        .lk_req(lk_req), .lk_ea(lk_ea),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_index(cmd_index), .cmd_data(cmd_data),
        .lk_vld_o(lk_vld_o), .lk_hit_o(lk_hit_o), .lk_idx_o(lk_idx_o), .lk_vsid_o(lk_vsid_o),
        .rd_vld_o(rd_vld_o), .rd_data_o(rd_data_o), .prog_err_o(prog_err_o), .flush_o(flush_o)
    );

    function automatic bit m_hit(input int s, input logic [63:0] ea);
        logic [1:0] sz = m_desc[s][63:62];
        return ((m_tag[s] == ((ea & MS) | VB)) && sz == 2'b00) ||
               ((m_tag[s] == ((ea & ML) | VB)) && sz == 2'b01);
    endfunction

    function automatic int m_find(input logic [63:0] ea);
        for (int s = 0; s < 32; s++) if (m_hit(s, ea)) return s;
        return -1;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, apply to the model, compare at the next falling edge
    task automatic step(input bit lr, input logic [63:0] lea, input bit cv, input logic [2:0] op,
                        input logic [63:0] idx, input logic [63:0] dat, input bit en);
        int f, s;
        bit e_hit, e_rv, e_err, e_fl, bad;
        logic [4:0] e_idx;
        logic [63:0] e_vs, e_rd;
        logic [11:0] sl;
        lk_req = lr; lk_ea = lea; cmd_valid = cv; cmd_op = op;
        cmd_index = idx; cmd_data = dat; seg1t_en = en;
        // R12: lookup uses the contents before this cycle's command
        f = m_find(lea);
        e_hit = lr && (f >= 0);
        e_idx = e_hit ? 5'(f) : 5'd0;
        e_vs  = e_hit ? m_desc[f] : 64'd0;
        e_rv = 0; e_rd = '0; e_err = 0; e_fl = 0;
        sl = idx[11:0];
        if (cv) begin
            case (op)
                3'd1: begin // R7 reserved slot bits, R8 size legality
                    bad = (sl[11:5] != 0) || dat[63] || (dat[63:62] == 2'b01 && !en);
                    if (bad) e_err = 1;
                    else begin m_tag[sl[4:0]] = idx & KEEP; m_desc[sl[4:0]] = dat; end
                end
                3'd2, 3'd3: begin // R9
                    if (sl >= 32) e_err = 1;
                    else begin e_rv = 1; e_rd = (op == 3'd2) ? m_tag[sl[4:0]] : m_desc[sl[4:0]]; end
                end
                3'd4: begin // R11
                    s = m_find(idx);
                    if (s >= 0) begin m_tag[s][27] = 1'b0; e_fl = 1; end
                end
                3'd5: begin // R10
                    for (int k = 1; k < 32; k++) begin
                        if (m_tag[k][27]) e_fl = 1;
                        m_tag[k][27] = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        @(negedge clk);
        check("R5 lk_vld", 64'(lk_vld_o), 64'(lr));
        check("R4 lk_hit", 64'(lk_hit_o), 64'(e_hit));
        check("R4 lk_idx", 64'(lk_idx_o), 64'(e_idx));
        check("R2 lk_vsid", lk_vsid_o, e_vs);
        check("R9 rd_vld", 64'(rd_vld_o), 64'(e_rv));
        check("R6 rd_data", rd_data_o, e_rd);
        check("R7 prog_err", 64'(prog_err_o), 64'(e_err));
        check("R10 flush", 64'(flush_o), 64'(e_fl));
    endtask

    function automatic logic [63:0] gen_ea();
        return {pool_hi[$urandom % 4], pool_mid[$urandom % 4], 28'($urandom)};
    endfunction

    task automatic idle();
        step(0, '0, 0, 3'd0, '0, '0, 1);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [63:0] a, b, ix, dt;
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) begin
            pool_hi[i]  = 24'h5A_0000 + 24'(i * 24'h11);
            pool_mid[i] = 12'h100 + 12'(i * 3);
        end
        for (int i = 0; i < 32; i++) begin m_tag[i] = '0; m_desc[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state reads zero and nothing hits
        step(1, '0, 1, 3'd2, 64'd0, '0, 1);
        step(1, {pool_hi[0], pool_mid[0], 28'h0}, 1, 3'd3, 64'd31, '0, 1);

        a = {pool_hi[1], pool_mid[2], 28'h123_4567};
        // R3: 1 TB entry in slot 6; R2: 256 MB entry in slot 2 on the same address
        step(0, '0, 1, 3'd1, (a & ML) | VB | 64'h006, {2'b01, 62'h55}, 1);
        step(1, {a[63:40], 12'hFFF, 28'h0}, 0, 3'd0, '0, '0, 1);
        step(0, '0, 1, 3'd1, (a & MS) | VB | 64'h3_F002, {2'b00, 62'h77}, 1);
        // R4: both match, slot 2 wins
        step(1, a, 0, 3'd0, '0, '0, 1);
        // R6: stripped tag read-back
        step(0, '0, 1, 3'd2, 64'd2, '0, 1);
        // R7: reserved slot bit; R8: bad size codes, 1 TB disabled
        step(0, '0, 1, 3'd1, 64'h20, '0, 1);
        step(0, '0, 1, 3'd1, 64'd4, {2'b10, 62'h0}, 1);
        step(0, '0, 1, 3'd1, 64'd4, {2'b01, 62'h0}, 0);
        step(0, '0, 1, 3'd3, 64'd4, '0, 1);
        // R9: out-of-range read
        step(0, '0, 1, 3'd2, 64'd40, '0, 1);
        // R11 with R12: lookup and invalidate of the same slot together
        step(1, a, 1, 3'd4, a, '0, 1);
        step(1, a, 0, 3'd0, '0, '0, 1);
        step(0, '0, 1, 3'd4, 64'hDEAD_0000_0000_0000, '0, 1);
        // R10: slot 0 survives invalidate-all, second pass does not flush
        b = {pool_hi[3], pool_mid[1], 28'h0};
        step(0, '0, 1, 3'd1, b | VB, 64'h9, 1);
        step(0, '0, 1, 3'd5, '0, '0, 1);
        step(1, b, 1, 3'd5, '0, '0, 1);
        idle();

        for (int n = 0; n < 3000; n++) begin
            int r;
            ix = gen_ea();
            r = $urandom % 100;
            ix[27] = (r < 92);
            ix[26:12] = 15'($urandom);
            ix[11:0] = 12'($urandom % 32);
            if ($urandom % 10 == 0) ix[5 + ($urandom % 7)] = 1'b1;
            dt = {$urandom, $urandom};
            dt[63:62] = ($urandom % 10 == 0) ? 2'(2 + $urandom % 2) : 2'($urandom % 2);
            r = $urandom % 100;
            if (r < 40)      step($urandom % 2 == 0, gen_ea(), 1, 3'd1, ix, dt, ($urandom % 10) != 0);
            else if (r < 55) step(1, gen_ea(), 1, 3'd2 + 3'($urandom % 2), {52'd0, 12'($urandom % 40)}, '0, 1);
            else if (r < 75) step(1, gen_ea(), 1, 3'd4, gen_ea(), '0, 1);
            else if (r < 78) step(1, gen_ea(), 1, 3'd5, '0, '0, 1);
            else             step(1, gen_ea(), 0, 3'd0, '0, '0, 1);
        end
        finish_run();
    end
endmodule